// File: doc/BRIEF.md
# GPIO Interrupt Detector and Status Collector

This block watches up to 95 already-synchronised general-purpose input levels and turns them into interrupt events. Each pin carries two configuration bits: one chooses between edge and level sensing, and the other flips the active polarity. A pin is watched only while it is in general-purpose mode, its input sensing is switched on, and the host owns it. Every event is latched into a sticky status bit. The status bits, and a matching set of enable bits, are packed into 32-bit words that software reaches through a simple register port. Software clears status bits by writing ones to them.

The block drives one interrupt line toward a parent interrupt controller. That line is registered, and it is high whenever any host-owned pin has both its status bit and its enable bit set. In use, software enables the pins it cares about. When the line rises it reads the status words, handles the pins whose bits are set, and then writes those bits back to acknowledge them.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every status bit and every enable bit is 0 and `irq_out` is 0. The edge reference follows the pin level even during reset, so a pin that is already high when reset is released does not count as a rising edge.
- R2: With level-select 0 and flip 0 (rising edge), a pin sampled low on one clock edge and high on the next sets its status bit, and the bit is readable right after that second edge. A level that stays high does not raise a fresh event.
- R3: With level-select 0 and flip 1 (falling edge), a transition from high to low sets the status bit, and a transition from low to high does not.
- R4: With level-select 1 and flip 0 (active-low level), the status bit is set again on every clock edge while the pin is low. A clear written during that time has no effect.
- R5: With level-select 1 and flip 1 (active-high level), the status bit is set on every clock edge while the pin is high, and it is never set while the pin is low.
- R6: A write to a status word clears each status bit whose data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears the whole word, and writing 0 changes nothing.
- R7: If a clear and a new event for the same pin arrive on the same clock edge, the status bit stays set.
- R8: Status words sit at byte addresses 0x80, 0x84 and 0x88, and enable words sit at 0x90, 0x94 and 0x98. Pin p uses word p/32, bit p mod 32. A write to an enable word replaces it. Bits with no pin behind them (bit 31 of the third word) read 0. Any other address, including an unaligned one, reads 0.
- R9: `irq_out` equals, one clock later, the OR over all pins of status AND enable AND owned. A status bit with its enable bit cleared does not raise `irq_out`.
- R10: A pin whose `host_owned` bit is 0 never sets its status bit and never contributes to `irq_out`.
- R11: A pin with `pad_is_gpio` at 0 or `sense_on` at 0 does not set its status bit. When sensing resumes while the pin is held steady, no edge is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 95 | Synchronised pin levels |
| trig_is_level | input | 95 | Per pin: 1 selects level sensing, 0 selects edge sensing |
| trig_flip | input | 95 | Per pin polarity: 0 for rising or low, 1 for falling or high |
| pad_is_gpio | input | 95 | Per pin: 1 when the pad is in general-purpose mode |
| sense_on | input | 95 | Per pin: 1 when input sensing is enabled |
| host_owned | input | 95 | Per pin: 1 when the host may take interrupts from the pin |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bound checker checks the following on every cycle, for each pin:
- A qualified edge or an active level always leaves the status bit set, even when a clear arrives on the same edge.
- A clear with no qualified event empties the bit.
- Unowned or unqualified pins stay quiet.
- `irq_out` follows the masked OR of the previous cycle.
- Unpopulated read bits stay zero.

Some behaviours only the bench's scenarios can show, because they need a sequence of stimulus:
- A steady high level gives exactly one rising event.
- A clear written while a low-level trigger is active is ignored until the level goes away.
- Writing 0 to a status word keeps it unchanged.
- Enable words read back what was written.
- Re-enabling sensing on a steady pin reports no false edge.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register map and trigger decode for the GPIO interrupt block.
// Assumes byte addressing with 32-bit word spacing of 4.
package gpio_irq_pkg;

    localparam int unsigned STATUS_BASE = 'h80;
    localparam int unsigned ENABLE_BASE = 'h90;
    localparam int unsigned WORD_STRIDE = 4;

    // Trigger kinds named after the two configuration bits {level, flip}.
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_kind_e;

    // Decide whether one pin reports an event this cycle.
    function automatic logic trig_hit(input logic is_level, input logic flip,
                                      input logic cur, input logic prev);
        trig_kind_e kind;
        kind = trig_kind_e'({is_level, flip});
        case (kind)
            TRIG_RISE: return cur & ~prev;
            TRIG_FALL: return ~cur & prev;
            TRIG_LOW:  return ~cur;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector.
// Compares each pin's current sample with the sample from the previous cycle,
// applies the pin's trigger kind, and gates the result with the pin's
// qualifiers (general-purpose mode, sensing on, host owned).
// Assumes pin levels are already synchronised to clk.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] trig_is_level,
    input  logic [NUM_PINS-1:0] trig_flip,
    input  logic [NUM_PINS-1:0] pad_is_gpio,
    input  logic [NUM_PINS-1:0] sense_on,
    input  logic [NUM_PINS-1:0] host_owned,
    output logic [NUM_PINS-1:0] event_vec
);

    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] qualified;

    // Edge reference: follows the pin every cycle, reset included, so that
    // leaving reset never produces a false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= pin_in;
        end else begin
            prev_q <= pin_in;
        end
    end

    // A pin is watched only when all three qualifiers are high.
    assign qualified = pad_is_gpio & sense_on & host_owned;

    // One decoder per pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign event_vec[p] = qualified[p] &
                              trig_hit(trig_is_level[p], trig_flip[p], pin_in[p], prev_q[p]);
    end

endmodule

// File: rtl/gpio_irq_store.sv
// Status and enable storage with a word-based register port.
// Status bits are sticky; writing a 1 clears a bit, but a new event on the
// same edge keeps it set. A write to an enable word replaces it.
// Bits with no pin behind them read as zero.
// Assumes a one-cycle write strobe and combinational reads.
module gpio_irq_store
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] event_vec,
    input  logic                csr_wr,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic [WORD_W-1:0]   csr_wdata,
    output logic [WORD_W-1:0]   csr_rdata,
    output logic [NUM_PINS-1:0] status_vec,
    output logic [NUM_PINS-1:0] enable_vec
);

    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    logic [NUM_WORDS-1:0] hit_stat;
    logic [NUM_WORDS-1:0] hit_en;
    logic [NUM_PINS-1:0]  clr_bits;
    logic [NUM_PINS-1:0]  en_wr_bits;
    logic [NUM_PINS-1:0]  en_wr_data;
    logic [NUM_PINS-1:0]  status_q;
    logic [NUM_PINS-1:0]  enable_q;
    logic [PAD_W-1:0]     stat_pad;
    logic [PAD_W-1:0]     en_pad;

    // Address decode: one status and one enable selector per word.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign hit_stat[w] = (csr_addr == ADDR_W'(STATUS_BASE + WORD_STRIDE * w));
        assign hit_en[w]   = (csr_addr == ADDR_W'(ENABLE_BASE + WORD_STRIDE * w));
    end

    // Spread the word write onto the pins it covers.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
        assign clr_bits[p]   = csr_wr & hit_stat[p / WORD_W] & csr_wdata[p % WORD_W];
        assign en_wr_bits[p] = csr_wr & hit_en[p / WORD_W];
        assign en_wr_data[p] = csr_wdata[p % WORD_W];
    end

    // Sticky status: clear first, then set by events, so events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | event_vec;
        end
    end

    // Enable words: a write replaces the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else begin
            enable_q <= (enable_q & ~en_wr_bits) | (en_wr_data & en_wr_bits);
        end
    end

    // Pad to whole words so that unpopulated bits read zero.
    always_comb begin
        stat_pad                 = '0;
        stat_pad[NUM_PINS-1:0]   = status_q;
        en_pad                   = '0;
        en_pad[NUM_PINS-1:0]     = enable_q;
    end

    // Read mux: the selected word, or zero for any other address.
    always_comb begin
        csr_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (hit_stat[w]) csr_rdata = stat_pad[w*WORD_W +: WORD_W];
            if (hit_en[w])   csr_rdata = en_pad[w*WORD_W +: WORD_W];
        end
    end

    assign status_vec = status_q;
    assign enable_vec = enable_q;

endmodule

// File: rtl/gpio_irq_merge.sv
// Combines all pending pins into one registered interrupt line.
// A pin is pending when its status, enable and ownership bits are all set.
// Assumes the parent controller can accept a single cycle of latency.
module gpio_irq_merge #(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] status_vec,
    input  logic [NUM_PINS-1:0] enable_vec,
    input  logic [NUM_PINS-1:0] host_owned,
    output logic                irq_out
);

    logic irq_q;

    // Register the OR of the pending pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_vec & enable_vec & host_owned);
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top level: GPIO interrupt detection, status and enable words, and the
// combined interrupt line.
// Assumes inputs are synchronous to clk and the register port is driven
// by a single master.
module gpio_irq_ctrl #(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] trig_is_level,
    input  logic [NUM_PINS-1:0] trig_flip,
    input  logic [NUM_PINS-1:0] pad_is_gpio,
    input  logic [NUM_PINS-1:0] sense_on,
    input  logic [NUM_PINS-1:0] host_owned,
    input  logic                csr_wr,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic [WORD_W-1:0]   csr_wdata,
    output logic [WORD_W-1:0]   csr_rdata,
    output logic                irq_out
);

    logic [NUM_PINS-1:0] event_vec;
    logic [NUM_PINS-1:0] status_vec;
    logic [NUM_PINS-1:0] enable_vec;

    // Per-pin detection.
    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .trig_is_level (trig_is_level),
        .trig_flip     (trig_flip),
        .pad_is_gpio   (pad_is_gpio),
        .sense_on      (sense_on),
        .host_owned    (host_owned),
        .event_vec     (event_vec)
    );

    // Status and enable words.
    gpio_irq_store #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_vec  (event_vec),
        .csr_wr     (csr_wr),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .status_vec (status_vec),
        .enable_vec (enable_vec)
    );

    // Combined interrupt line.
    gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_vec (status_vec),
        .enable_vec (enable_vec),
        .host_owned (host_owned),
        .irq_out    (irq_out)
    );

endmodule

// File: rtl/gpio_irq_ctrl_checker.sv
// Checker for gpio_irq_ctrl, attached with bind below.
// Checks per-pin status behaviour and the timing of the interrupt line.
module gpio_irq_ctrl_checker
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] trig_is_level,
    input  logic [NUM_PINS-1:0] trig_flip,
    input  logic [NUM_PINS-1:0] pad_is_gpio,
    input  logic [NUM_PINS-1:0] sense_on,
    input  logic [NUM_PINS-1:0] host_owned,
    input  logic                csr_wr,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic [WORD_W-1:0]   csr_wdata,
    input  logic [WORD_W-1:0]   csr_rdata,
    input  logic                irq_out,
    input  logic [NUM_PINS-1:0] status_vec,
    input  logic [NUM_PINS-1:0] enable_vec
);

    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int LAST_USED = NUM_PINS - (NUM_WORDS - 1) * WORD_W;

    // The interrupt line is the masked OR of the previous cycle (R9).
    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(status_vec & enable_vec & host_owned)));

    // With nothing owned, the interrupt line stays low (R10).
    assert_irq_unowned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_owned == '0) |=> !irq_out);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // A qualified edge sets the bit, even when a clear arrives on the same edge (R2, R3, R7).
        assert_edge_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_is_gpio[p] && sense_on[p] && host_owned[p] && !trig_is_level[p] &&
             (pin_in[p] ^ trig_flip[p]) && !($past(pin_in[p]) ^ trig_flip[p]))
            |=> status_vec[p]);

        // An active level keeps the bit set whatever is written (R4, R5).
        assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_is_gpio[p] && sense_on[p] && host_owned[p] && trig_is_level[p] &&
             (pin_in[p] == trig_flip[p]))
            |=> status_vec[p]);

        // A clear of an unqualified pin empties its bit (R6).
        assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_wr && csr_addr == ADDR_W'(STATUS_BASE + WORD_STRIDE * (p / WORD_W)) &&
             csr_wdata[p % WORD_W] && !(pad_is_gpio[p] && sense_on[p]))
            |=> !status_vec[p]);

        // An unowned pin never sets its status bit (R10).
        assert_unowned_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!host_owned[p] && !status_vec[p]) |=> !status_vec[p]);

        // An unqualified pin never sets its status bit (R11).
        assert_unsensed_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!(pad_is_gpio[p] && sense_on[p]) && !status_vec[p]) |=> !status_vec[p]);
    end

    // Bits with no pin behind them read zero in the last words (R8).
    if (LAST_USED < WORD_W) begin : g_pad_chk
        assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_addr == ADDR_W'(STATUS_BASE + WORD_STRIDE * (NUM_WORDS - 1)) ||
             csr_addr == ADDR_W'(ENABLE_BASE + WORD_STRIDE * (NUM_WORDS - 1)))
            |-> (csr_rdata >> LAST_USED) == '0);
    end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_checker #(
    .NUM_PINS (NUM_PINS),
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_in        (pin_in),
    .trig_is_level (trig_is_level),
    .trig_flip     (trig_flip),
    .pad_is_gpio   (pad_is_gpio),
    .sense_on      (sense_on),
    .host_owned    (host_owned),
    .csr_wr        (csr_wr),
    .csr_addr      (csr_addr),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .irq_out       (irq_out),
    .status_vec    (status_vec),
    .enable_vec    (enable_vec)
);

// File: tb/gpio_irq_ctrl_test.sv
// Bench for gpio_irq_ctrl.
// A behavioural reference model is compared with the design on every clock,
// and directed scenarios check hand-computed values.
module gpio_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int NUM_PINS   = 95;
    localparam int WATCHDOG   = 100000;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NUM_PINS-1:0] pin_in, trig_is_level, trig_flip, pad_is_gpio, sense_on, host_owned;
    logic                csr_wr;
    logic [7:0]          csr_addr;
    logic [31:0]         csr_wdata;
    logic [31:0]         csr_rdata;
    logic                irq_out;

    int checks = 0;
    int fails  = 0;

    gpio_irq_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .trig_is_level (trig_is_level),
        .trig_flip     (trig_flip),
        .pad_is_gpio   (pad_is_gpio),
        .sense_on      (sense_on),
        .host_owned    (host_owned),
        .csr_wr        (csr_wr),
        .csr_addr      (csr_addr),
        .csr_wdata     (csr_wdata),
        .csr_rdata     (csr_rdata),
        .irq_out       (irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- reference model ----------------
    bit m_stat [NUM_PINS];
    bit m_en   [NUM_PINS];
    bit m_prev [NUM_PINS];
    bit m_irq;
    bit model_live = 1'b0;
    bit ev, act, clr;

    // Model update at each rising edge, using the inputs held since the previous quarter cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                m_stat[p] = 1'b0;
                m_en[p]   = 1'b0;
            end
            m_irq      = 1'b0;
            model_live = 1'b1;
        end else begin
            m_irq = 1'b0;
            for (int p = 0; p < NUM_PINS; p++)
                if (m_stat[p] && m_en[p] && host_owned[p]) m_irq = 1'b1;
            for (int p = 0; p < NUM_PINS; p++) begin
                act = pad_is_gpio[p] && sense_on[p] && host_owned[p];
                if (trig_is_level[p]) ev = (pin_in[p] == trig_flip[p]);
                else if (trig_flip[p]) ev = m_prev[p] && !pin_in[p];
                else ev = !m_prev[p] && pin_in[p];
                ev  = ev && act;
                clr = csr_wr && (csr_addr == 8'(8'h80 + 4 * (p / 32))) && csr_wdata[p % 32];
                m_stat[p] = (m_stat[p] && !clr) || ev;
                if (csr_wr && (csr_addr == 8'(8'h90 + 4 * (p / 32)))) m_en[p] = csr_wdata[p % 32];
            end
        end
        for (int p = 0; p < NUM_PINS; p++) m_prev[p] = pin_in[p];
    end

    // Expected read data of the model for one address.
    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (a == 8'(8'h80 + 4 * (p / 32))) r[p % 32] = m_stat[p];
            if (a == 8'(8'h90 + 4 * (p / 32))) r[p % 32] = m_en[p];
        end
        return r;
    endfunction

    // Compare on every clock, half a period after the edge.
    always @(negedge clk) begin
        if (model_live && rst_n === 1'b1) begin
            checks += 2;
            if (csr_rdata !== model_read(csr_addr)) begin
                fails++;
                $display("FAIL R8 per-cycle read addr=%h actual=%h expected=%h",
                         csr_addr, csr_rdata, model_read(csr_addr));
            end
            if (irq_out !== m_irq) begin
                fails++;
                $display("FAIL R9 per-cycle irq actual=%b expected=%b", irq_out, m_irq);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #(QTR);
    endtask

    task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp_v);
        csr_addr = a;
        #1;
        check(tag, csr_rdata, exp_v);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        csr_wr    = 1'b1;
        csr_addr  = a;
        csr_wdata = d;
        tick(1);
        csr_wr    = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    // ---------------- scenarios ----------------
    initial begin
        rst_n = 1'b0;
        pin_in = '0; trig_is_level = '0; trig_flip = '0;
        pad_is_gpio = '1; sense_on = '1; host_owned = '1;
        csr_wr = 1'b0; csr_addr = 8'h80; csr_wdata = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd_check("R1 status0", 8'h80, 32'h0);
        rd_check("R1 status2", 8'h88, 32'h0);
        rd_check("R1 enable1", 8'h94, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);

        // R2 rising edge on pin 5, a single event for a steady high
        pin_in[5] = 1'b1;
        tick(1);
        rd_check("R2 rise sets", 8'h80, 32'h0000_0020);
        wr(8'h80, 32'h0000_0020);
        tick(2);
        rd_check("R2 no repeat on steady high", 8'h80, 32'h0);

        // R3 falling edge on pin 40 (word 1 bit 8)
        trig_flip[40] = 1'b1;
        pin_in[40] = 1'b1;
        tick(1);
        rd_check("R3 rise ignored", 8'h84, 32'h0);
        pin_in[40] = 1'b0;
        tick(1);
        rd_check("R3 fall sets", 8'h84, 32'h0000_0100);

        // R6 writing zero keeps, all ones clears
        wr(8'h84, 32'h0);
        rd_check("R6 zero write keeps", 8'h84, 32'h0000_0100);
        wr(8'h84, 32'hFFFF_FFFF);
        rd_check("R6 all-ones clears", 8'h84, 32'h0);

        // R4 low level on pin 70 (word 2 bit 6): a clear is ignored while active
        trig_is_level[70] = 1'b1;
        tick(1);
        rd_check("R4 low level sets", 8'h88, 32'h0000_0040);
        wr(8'h88, 32'h0000_0040);
        rd_check("R4 clear ignored while low", 8'h88, 32'h0000_0040);
        pin_in[70] = 1'b1;
        wr(8'h88, 32'h0000_0040);
        rd_check("R4 clear after level gone", 8'h88, 32'h0);

        // R5 high level on pin 94 (word 2 bit 30)
        trig_is_level[94] = 1'b1;
        trig_flip[94] = 1'b1;
        tick(1);
        rd_check("R5 low pin no event", 8'h88, 32'h0);
        pin_in[94] = 1'b1;
        tick(1);
        rd_check("R5 high level sets", 8'h88, 32'h4000_0000);
        pin_in[94] = 1'b0;
        wr(8'h88, 32'h4000_0000);
        rd_check("R5 cleared after low", 8'h88, 32'h0);

        // R7 a clear and a rising edge on pin 2 land on the same edge
        pin_in[2] = 1'b1;
        wr(8'h80, 32'h0000_0004);
        rd_check("R7 event wins over clear", 8'h80, 32'h0000_0004);
        wr(8'h80, 32'h0000_0004);
        rd_check("R7 later clear works", 8'h80, 32'h0);

        // R8 enable words, unpopulated bit, stray addresses
        wr(8'h94, 32'hA5A5_A5A5);
        rd_check("R8 enable readback", 8'h94, 32'hA5A5_A5A5);
        wr(8'h98, 32'hFFFF_FFFF);
        rd_check("R8 pin 95 bit reads zero", 8'h98, 32'h7FFF_FFFF);
        rd_check("R8 unmapped address", 8'hA0, 32'h0);
        rd_check("R8 unaligned address", 8'h82, 32'h0);
        wr(8'h94, 32'h0);
        wr(8'h98, 32'h0);

        // R9 latency and masking
        wr(8'h90, 32'h0000_0004);
        pin_in[2] = 1'b0;
        tick(1);
        pin_in[2] = 1'b1;
        tick(1);
        check("R9 irq not yet", {31'b0, irq_out}, 32'h0);
        tick(1);
        check("R9 irq raised", {31'b0, irq_out}, 32'h1);
        wr(8'h80, 32'h0000_0004);
        check("R9 irq one cycle after clear", {31'b0, irq_out}, 32'h1);
        tick(1);
        check("R9 irq dropped", {31'b0, irq_out}, 32'h0);
        pin_in[5] = 1'b0;
        tick(1);
        pin_in[5] = 1'b1;
        tick(2);
        check("R9 disabled pin no irq", {31'b0, irq_out}, 32'h0);
        rd_check("R9 disabled pin status", 8'h80, 32'h0000_0020);
        wr(8'h80, 32'h0000_0020);

        // R10 unowned pin 60 (word 1 bit 28)
        host_owned[60] = 1'b0;
        wr(8'h94, 32'h1000_0000);
        pin_in[60] = 1'b1;
        tick(2);
        rd_check("R10 unowned no status", 8'h84, 32'h0);
        check("R10 unowned no irq", {31'b0, irq_out}, 32'h0);

        // R11 not in GPIO mode (pin 61) or sensing off (pin 62)
        pad_is_gpio[61] = 1'b0;
        pin_in[61] = 1'b1;
        tick(2);
        rd_check("R11 non-gpio pin quiet", 8'h84, 32'h0);
        sense_on[62] = 1'b0;
        pin_in[62] = 1'b1;
        tick(2);
        rd_check("R11 sensing off quiet", 8'h84, 32'h0);
        sense_on[62] = 1'b1;
        pad_is_gpio[61] = 1'b1;
        tick(2);
        rd_check("R11 no false edge on resume", 8'h84, 32'h0);

        summary();
    end

endmodule